// File: doc/BRIEF.md
# Prescaled Baud Rate Generator

This block turns a fast reference clock into the timing strobes that a UART's transmitter and receiver run on. A fixed divide-by-ten stage reduces an 18.432 MHz reference to the customary 1.8432 MHz UART rate. It does so as a one-cycle enable on the reference clock, not as a new clock. A static select input feeds either that prescaled enable or the undivided reference (an enable on every cycle) into a 16-bit programmable divider. The divider's output is a single-cycle strobe at sixteen times the baud rate. A second strobe marks every sixteenth of those and paces the bit rate.

The divisor is written one byte at a time through a shared byte bus and two write strobes. Each write forces the divider into its reload state. The new value therefore takes hold at the next enable, with no reset needed. The baud rate equals the selected input rate divided by sixteen times the divisor. With the prescaled path, a divisor of 12 gives 9600 baud, 2304 gives 50 baud, 1047 gives 110 baud (0.026 % error) and 2 gives about 56000 baud (2.86 % error). A divisor of zero counts as 65536.

The divider is a two-state machine. The state ST_RELOAD is entered at reset and on any divisor write. In ST_RELOAD, the next input enable loads the counter with divisor minus one and takes the transition to ST_RUN. In ST_RUN, each enable decrements the counter. An enable that finds the counter at zero raises the 16x strobe and reloads the counter, remaining in ST_RUN. A divisor write moves the machine from either state to ST_RELOAD.

Top module: `baudgen`

## Requirements
- R1: During reset and after it, both strobes are low, the divisor is 12 and the first interval between 16x strobes in prescaled mode is 120 reference cycles.
- R2: With the select input low (prescaled path), the 16x strobe recurs every 10 × divisor reference cycles.
- R3: With the select input high (undivided reference), the 16x strobe recurs every divisor reference cycles.
- R4: The divisor's bits 7:0 come from a low-byte write and bits 15:8 from a high-byte write; writing one byte leaves the other unchanged.
- R5: In prescaled mode the 16x strobe is never high on two consecutive cycles.
- R6: On the cycle after any divisor write the 16x strobe is low. With the undivided reference, the first strobe after the last write appears divisor + 1 cycles after the write edge.
- R7: A divisor of 0 acts as 65536: with the undivided reference, the first strobe comes 65537 cycles after the write.
- R8: The bit-rate strobe is high only together with the 16x strobe, on every sixteenth 16x strobe counted from reset, so bit strobes are 16 × the 16x interval apart.
- R9: A divisor of 1 with the undivided reference holds the 16x strobe high on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock (18.432 MHz nominal) |
| rst_ni | input | 1 | Active-low synchronous reset |
| use_ref_i | input | 1 | Static select: 1 feeds the undivided reference, 0 the divide-by-ten path |
| div_lo_we_i | input | 1 | Write strobe for divisor bits 7:0 |
| div_hi_we_i | input | 1 | Write strobe for divisor bits 15:8 |
| div_byte_i | input | 8 | Byte written to the divisor |
| tick16_o | output | 1 | One-cycle strobe at 16 × baud |
| bit_tick_o | output | 1 | One-cycle strobe at the bit rate |

## Verification
The hardest case to reach is the divisor of zero. The wrap to 65536 appears only after tens of thousands of cycles, and the prescaled path would make it ten times longer. The stimulus selects the undivided reference and writes a zero divisor. It then times the single gap from that write to the first strobe, which is the same wrap without the prescaler's cost. The exact reload latency after a write is found the same way: a two-byte write lands while a long count is in progress, and the cycle of the following strobe is counted.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

    typedef enum logic [0:0] {
        ST_RELOAD = 1'b0,
        ST_RUN    = 1'b1
    } div_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/baudgen_prescale.sv
module baudgen_prescale #(
    parameter int RATIO = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic use_ref_i,
    output logic en_o
);
    localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;

    logic pre_pulse;

    generate
        if (RATIO > 1) begin : g_div
            logic [CW-1:0] pcnt_q;

            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    pcnt_q <= '0;
                end else if (pcnt_q == CW'(RATIO - 1)) begin
                    pcnt_q <= '0;
                end else begin
                    pcnt_q <= pcnt_q + 1'b1;
                end
            end

            assign pre_pulse = (pcnt_q == CW'(RATIO - 1));
        end else begin : g_nodiv
            assign pre_pulse = 1'b1;
        end
    endgenerate

    assign en_o = use_ref_i | pre_pulse;

endmodule

// File: rtl/baudgen_divreg.sv
module baudgen_divreg #(
    parameter int DIV_W   = 16,
    parameter int RST_DIV = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lo_we_i,
    input  logic             hi_we_i,
    input  logic [7:0]       byte_i,
    output logic [DIV_W-1:0] div_o,
    output logic             load_o
);
    localparam int HI_W = DIV_W - baudgen_pkg::BYTE_W;
    localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(RST_DIV);

    logic [7:0]      lo_q;
    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lo_q <= RST_VAL[7:0];
            hi_q <= RST_VAL[DIV_W-1:8];
        end else begin
            if (lo_we_i) begin
                lo_q <= byte_i;
            end
            if (hi_we_i) begin
                hi_q <= byte_i[HI_W-1:0];
            end
        end
    end

    assign div_o  = {hi_q, lo_q};
    assign load_o = lo_we_i | hi_we_i;

endmodule

// File: rtl/baudgen_divcnt.sv
module baudgen_divcnt
    import baudgen_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             load_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    div_state_e       state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic             tick_d, tick_q;
    logic [DIV_W-1:0] reload_val;

    assign reload_val = div_i - 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        tick_d  = 1'b0;
        if (load_i) begin
            state_d = ST_RELOAD;
        end else if (en_i) begin
            unique case (state_q)
                ST_RELOAD: begin
                    cnt_d   = reload_val;
                    state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (cnt_q == '0) begin
                        tick_d = 1'b1;
                        cnt_d  = reload_val;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_RELOAD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= tick_d;
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/baudgen_bitcnt.sv
module baudgen_bitcnt #(
    parameter int OVS = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    output logic bit_tick_o
);
    localparam int BW = $clog2(OVS);

    logic [BW-1:0] bcnt_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            bcnt_q <= '0;
        end else if (tick_i) begin
            if (bcnt_q == BW'(OVS - 1)) begin
                bcnt_q <= '0;
            end else begin
                bcnt_q <= bcnt_q + 1'b1;
            end
        end
    end

    assign bit_tick_o = tick_i && (bcnt_q == BW'(OVS - 1));

endmodule

// File: rtl/baudgen.sv
module baudgen #(
    parameter int PRESCALE = 10,
    parameter int DIV_W    = 16,
    parameter int RST_DIV  = 12,
    parameter int OVS      = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       use_ref_i,
    input  logic       div_lo_we_i,
    input  logic       div_hi_we_i,
    input  logic [7:0] div_byte_i,
    output logic       tick16_o,
    output logic       bit_tick_o
);
    logic             clk_en;
    logic             div_load;
    logic [DIV_W-1:0] div_val;

    baudgen_prescale #(.RATIO(PRESCALE)) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .use_ref_i (use_ref_i),
        .en_o      (clk_en)
    );

    baudgen_divreg #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_reg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .lo_we_i (div_lo_we_i),
        .hi_we_i (div_hi_we_i),
        .byte_i  (div_byte_i),
        .div_o   (div_val),
        .load_o  (div_load)
    );

    baudgen_divcnt #(.DIV_W(DIV_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (clk_en),
        .load_i (div_load),
        .div_i  (div_val),
        .tick_o (tick16_o)
    );

    baudgen_bitcnt #(.OVS(OVS)) u_bit (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick16_o),
        .bit_tick_o (bit_tick_o)
    );

endmodule

// File: rtl/baudgen_chk.sv
module baudgen_chk #(
    parameter int OVS = 16
) (
    input logic clk_i,
    input logic rst_ni,
    input logic use_ref_i,
    input logic div_lo_we_i,
    input logic div_hi_we_i,
    input logic tick16_o,
    input logic bit_tick_o
);
    localparam int BW = $clog2(OVS);

    logic [BW-1:0] seen_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seen_q <= '0;
        end else if (tick16_o) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    AST_BIT_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_tick_o |-> tick16_o); // R8

    AST_BIT_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_tick_o |-> (seen_q == BW'(OVS - 1))); // R8

    AST_BIT_NOT_MISSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick16_o && seen_q == BW'(OVS - 1)) |-> bit_tick_o); // R8

    AST_PRESCALED_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick16_o && !use_ref_i) |=> !tick16_o); // R5

    AST_WRITE_HOLDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_lo_we_i || div_hi_we_i) |=> !tick16_o); // R6

endmodule

bind baudgen baudgen_chk #(.OVS(OVS)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .use_ref_i   (use_ref_i),
    .div_lo_we_i (div_lo_we_i),
    .div_hi_we_i (div_hi_we_i),
    .tick16_o    (tick16_o),
    .bit_tick_o  (bit_tick_o)
);

// File: tb/baudgen_tb.sv
module baudgen_tb;

    typedef struct packed {
        logic        byp;
        logic [7:0]  hi;
        logic [7:0]  lo;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h00, 8'h0C, 32'd120},
        '{1'b1, 8'h00, 8'h0C, 32'd12},
        '{1'b0, 8'h00, 8'h02, 32'd20},
        '{1'b1, 8'h00, 8'h02, 32'd2},
        '{1'b1, 8'h09, 8'h00, 32'd2304},
        '{1'b1, 8'h04, 8'h17, 32'd1047},
        '{1'b0, 8'h00, 8'h01, 32'd10},
        '{1'b1, 8'h00, 8'h01, 32'd1},
        '{1'b1, 8'h00, 8'h03, 32'd3}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       use_ref;
    logic       lo_we;
    logic       hi_we;
    logic [7:0] dbyte;
    logic       tick16;
    logic       bit_tick;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    baudgen u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .use_ref_i   (use_ref),
        .div_lo_we_i (lo_we),
        .div_hi_we_i (hi_we),
        .div_byte_i  (dbyte),
        .tick16_o    (tick16),
        .bit_tick_o  (bit_tick)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cyc == 190000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: run exceeded cycle limit, actual %0d expected below 190000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit hi, input logic [7:0] v);
        @(negedge clk);
        lo_we = !hi;
        hi_we = hi;
        dbyte = v;
        @(negedge clk);
        lo_we = 1'b0;
        hi_we = 1'b0;
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n = n + 1;
        end while (!tick16 && n < 70000);
    endtask

    task automatic wait_bit(output int n, output int t16, output int both);
        n = 0;
        t16 = 0;
        both = 1;
        do begin
            @(negedge clk);
            n = n + 1;
            if (tick16) t16 = t16 + 1;
            if (bit_tick && !tick16) both = 0;
        end while (!bit_tick && n < 70000);
    endtask

    initial begin
        int n;
        int t16;
        int both;
        string tag;
        rst_n   = 1'b0;
        use_ref = 1'b0;
        lo_we   = 1'b0;
        hi_we   = 1'b0;
        dbyte   = 8'h00;

        repeat (3) @(negedge clk);
        check("R1 tick16 in reset", int'(tick16), 0);
        check("R1 bit_tick in reset", int'(bit_tick), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tick16 after reset", int'(tick16), 0);
        // R1: default divisor 12, prescaled path
        wait_tick(n);
        wait_tick(n);
        check("R1 default interval", n, 120);

        // Vector table walk: R2 prescaled, R3 undivided, R9 divisor one
        for (int i = 0; i < NVEC; i++) begin
            use_ref = VECS[i].byp;
            wr(1'b1, VECS[i].hi);
            wr(1'b0, VECS[i].lo);
            wait_tick(n);
            wait_tick(n);
            if (!VECS[i].byp) tag = "R2";
            else if (VECS[i].exp == 1) tag = "R9";
            else tag = "R3";
            check($sformatf("%s vector %0d interval", tag, i), n, int'(VECS[i].exp));
        end

        // R9: divisor one on reference holds strobe every cycle
        use_ref = 1'b1;
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h01);
        repeat (4) @(negedge clk);
        check("R9 continuous high", int'(tick16), 1);

        // R4: byte writes retain the other byte
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h00);
        wait_tick(n);
        wait_tick(n);
        check("R4 both bytes 0x0100", n, 256);
        wr(1'b0, 8'h02);
        wait_tick(n);
        wait_tick(n);
        check("R4 low byte only 0x0102", n, 258);
        wr(1'b1, 8'h00);
        wait_tick(n);
        wait_tick(n);
        check("R4 high byte only 0x0002", n, 2);

        // R6: reload mid-count
        wr(1'b1, 8'h04);
        wr(1'b0, 8'h17);
        wait_tick(n);
        repeat (100) @(negedge clk);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h03);
        check("R6 low right after write", int'(tick16), 0);
        wait_tick(n);
        check("R6 reload latency", n, 4);
        wait_tick(n);
        check("R6 new interval", n, 3);

        // R8: bit strobe spacing on divisor 2 via reference
        wr(1'b0, 8'h02);
        wait_bit(n, t16, both);
        wait_bit(n, t16, both);
        check("R8 bit interval", n, 32);
        check("R8 strobes per bit", t16, 16);
        check("R8 bit with tick16", both, 1);

        // R7: zero divisor wraps to 65536
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h00);
        wait_tick(n);
        check("R7 zero divisor latency", n, 65537);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule